// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block translates a virtual address into a page-aligned physical address. It reads directory and leaf table entries from memory one at a time. Five configuration slots give a bit position and an index width. Slots 4 down to 1 are the directory levels and slot 0 is the leaf table. Two root pointers, one for each half of the address space, complete the configuration. The walker reports the physical page address, whether the page may be written, and whether the final entry was invalid (no-match).

A walk begins with a one-cycle `start_i` pulse while the walker is idle. The walker captures the address, the roots and every configuration slot at that moment. It then moves down the levels and skips any level whose width is zero without touching memory. Each entry is fetched over a request/response port that allows one read in flight. A directory entry with its huge-page bit set ends the walk early and is rewritten into a leaf entry. Otherwise a final leaf read supplies the entry. `done_o` pulses for one cycle with the results, and the walker returns to idle.

The control state machine has five states. IDLE waits for start; start moves it to PICK. PICK selects the current level: it steps down past zero-width levels and stays in PICK, and it moves to ISSUE for a level with a non-zero width or for the leaf slot. ISSUE drives a one-cycle read request and moves to WAIT. WAIT holds until the response arrives. A directory entry without the huge bit goes back to PICK one level lower. A huge directory entry or the leaf entry goes to DONE. DONE pulses done for one cycle and returns to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: Virtual address bit 63 selects the root pointer: the high-half root when the bit is 1, the low-half root when it is 0. The chosen root is masked to PA_W bits.
- R2: Directory levels are visited in the order 4, 3, 2, 1. A level whose configured width is zero issues no memory read.
- R3: Every read address equals the current base OR'd with the index shifted left by 3, truncated to PA_W bits. The index is `(va >> position) & ((1 << width) - 1)`. Slot k of the flat configuration buses occupies bits [6k+5:6k].
- R4: A fetched directory entry, masked to PA_W bits, becomes the base for the next level. If its bit 6 (huge) is set, no further read is made.
- R5: A huge entry has bits 14:13 (level) and bit 6 cleared. If its bit 12 (huge-global) is set, bit 12 is cleared and bit 7 (global) is set.
- R6: When no huge entry was met, exactly one more read is made using the slot 0 position and width, and the unmasked result is the leaf entry.
- R7: `nomatch_o` is the inverse of leaf bit 0 (valid), and `write_o` equals leaf bit 1 (dirty).
- R8: `phys_o` is the entry plus `(va & PA mask & ((1 << p) - 1))`, where p is the position of the last slot read. Bits 63:61 are then cleared, along with the low PAGE_SHIFT bits.
- R9: At most one read is in flight: `mem_req_o` is a single-cycle pulse and never asserts again before the response.
- R10: `start_i` is taken only in idle. `busy_o` stays high from the cycle after start through the done cycle. `done_o` is a one-cycle pulse followed by idle.
- R11: Changes to the roots or the configuration during a walk have no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a walk (idle only) |
| va_i | input | 64 | Virtual address to translate |
| root_lo_i | input | 64 | Root pointer for addresses with bit 63 clear |
| root_hi_i | input | 64 | Root pointer for addresses with bit 63 set |
| cfg_pos_i | input | 30 | Five 6-bit bit positions, slot 0 leaf, slots 1-4 directories |
| cfg_width_i | input | 30 | Five 6-bit index widths, same slot layout |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse; results valid |
| phys_o | output | 64 | Physical page address |
| write_o | output | 1 | Page is writable |
| nomatch_o | output | 1 | Leaf entry invalid |
| mem_req_o | output | 1 | Single-cycle read request |
| mem_addr_o | output | PA_W | Read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Read response data |

## Verification
The assertions assume three things about the environment. A response arrives only while a read is pending. Exactly one response arrives per request. `start_i` pulses only while the walker is idle. The bench's memory responder answers each request exactly once, after a chosen latency of one to three cycles. The stimulus raises `start_i` only after the previous walk's done pulse has passed. The bench changes configuration mid-walk only on the dedicated test, where the walker is expected to ignore it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ENTRY_W  = 64;
    localparam int CFG_W    = 6;
    localparam int NUM_DIR  = 4;
    localparam int NUM_SLOT = NUM_DIR + 1;
    localparam int LVL_W    = 3;

    localparam int BIT_VALID  = 0;
    localparam int BIT_DIRTY  = 1;
    localparam int BIT_HUGE   = 6;
    localparam int BIT_GLOBAL = 7;
    localparam int BIT_HGLOB  = 12;
    localparam int BIT_LVL_LO = 13;
    localparam int BIT_LVL_HI = 14;
    localparam int BIT_TOP_LO = 61;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc
    import ptw_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic [ENTRY_W-1:0] va_i,
    input  logic [PA_W-1:0]    base_i,
    input  logic [CFG_W-1:0]   pos_i,
    input  logic [CFG_W-1:0]   width_i,
    output logic [PA_W-1:0]    addr_o
);
    logic [ENTRY_W-1:0] idx_mask;
    logic [ENTRY_W-1:0] idx;
    logic [ENTRY_W-1:0] wide_addr;

    always_comb begin
        idx_mask  = (64'd1 << width_i) - 64'd1;
        idx       = (va_i >> pos_i) & idx_mask;
        wide_addr = {{(ENTRY_W-PA_W){1'b0}}, base_i} | (idx << 3);
        addr_o    = wide_addr[PA_W-1:0];
    end
endmodule

// File: rtl/ptw_result_fmt.sv
module ptw_result_fmt
    import ptw_pkg::*;
#(
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic               huge_i,
    input  logic [CFG_W-1:0]   pos_i,
    input  logic [ENTRY_W-1:0] va_i,
    output logic [ENTRY_W-1:0] phys_o,
    output logic               write_o,
    output logic               nomatch_o
);
    localparam logic [ENTRY_W-1:0] PA_MASK = {{(ENTRY_W-PA_W){1'b0}}, {PA_W{1'b1}}};

    logic [ENTRY_W-1:0] ent;
    logic [ENTRY_W-1:0] offs;
    logic [ENTRY_W-1:0] sum;

    always_comb begin
        ent = entry_i;
        if (huge_i) begin
            ent[BIT_LVL_HI:BIT_LVL_LO] = '0;
            ent[BIT_HUGE]              = 1'b0;
            if (ent[BIT_HGLOB]) begin
                ent[BIT_HGLOB]  = 1'b0;
                ent[BIT_GLOBAL] = 1'b1;
            end
        end
        offs = va_i & PA_MASK & ((64'd1 << pos_i) - 64'd1);
        sum  = ent + offs;
        sum[ENTRY_W-1:BIT_TOP_LO] = '0;
        sum[PAGE_SHIFT-1:0]       = '0;
        phys_o    = sum;
        write_o   = ent[BIT_DIRTY];
        nomatch_o = ~ent[BIT_VALID];
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic [63:0]               va_i,
    input  logic [63:0]               root_lo_i,
    input  logic [63:0]               root_hi_i,
    input  logic [NUM_SLOT*CFG_W-1:0] cfg_pos_i,
    input  logic [NUM_SLOT*CFG_W-1:0] cfg_width_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [63:0]               phys_o,
    output logic                      write_o,
    output logic                      nomatch_o,
    output logic                      mem_req_o,
    output logic [PA_W-1:0]           mem_addr_o,
    input  logic                      mem_rvalid_i,
    input  logic [63:0]               mem_rdata_i
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_DIR);

    walk_state_e state_q, state_d;

    logic [LVL_W-1:0]          lvl_q;
    logic [63:0]               va_q;
    logic [NUM_SLOT*CFG_W-1:0] pos_q;
    logic [NUM_SLOT*CFG_W-1:0] wid_q;
    logic [PA_W-1:0]           base_q;
    logic [63:0]               entry_q;
    logic                      huge_q;
    logic [CFG_W-1:0]          last_pos_q;

    logic [CFG_W-1:0] pos_arr [NUM_SLOT];
    logic [CFG_W-1:0] wid_arr [NUM_SLOT];
    logic [CFG_W-1:0] cur_pos;
    logic [CFG_W-1:0] cur_wid;
    logic             rsp_huge;
    logic             outstanding_q;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        assign pos_arr[s] = pos_q[s*CFG_W +: CFG_W];
        assign wid_arr[s] = wid_q[s*CFG_W +: CFG_W];
    end

    assign cur_pos  = pos_arr[lvl_q];
    assign cur_wid  = wid_arr[lvl_q];
    assign rsp_huge = mem_rdata_i[BIT_HUGE];

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_PICK;
            ST_PICK:  if (lvl_q == '0 || cur_wid != '0) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    if (lvl_q == '0 || rsp_huge) state_d = ST_DONE;
                    else                         state_d = ST_PICK;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_q      <= '0;
            va_q       <= '0;
            pos_q      <= '0;
            wid_q      <= '0;
            base_q     <= '0;
            entry_q    <= '0;
            huge_q     <= 1'b0;
            last_pos_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        lvl_q  <= TOP_LVL;
                        va_q   <= va_i;
                        pos_q  <= cfg_pos_i;
                        wid_q  <= cfg_width_i;
                        base_q <= va_i[63] ? root_hi_i[PA_W-1:0] : root_lo_i[PA_W-1:0];
                        huge_q <= 1'b0;
                    end
                end
                ST_PICK: begin
                    if (lvl_q != '0 && cur_wid == '0) lvl_q <= lvl_q - 1'b1;
                end
                ST_WAIT: begin
                    if (mem_rvalid_i) begin
                        if (lvl_q == '0) begin
                            entry_q    <= mem_rdata_i;
                            last_pos_q <= cur_pos;
                        end else begin
                            base_q <= mem_rdata_i[PA_W-1:0];
                            if (rsp_huge) begin
                                entry_q    <= {{(64-PA_W){1'b0}}, mem_rdata_i[PA_W-1:0]};
                                huge_q     <= 1'b1;
                                last_pos_q <= cur_pos;
                            end else begin
                                lvl_q <= lvl_q - 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // request tracking for the checks below
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           outstanding_q <= 1'b0;
        else if (mem_req_o)    outstanding_q <= 1'b1;
        else if (mem_rvalid_i) outstanding_q <= 1'b0;
    end

    // outputs
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_DONE);
        mem_req_o = (state_q == ST_ISSUE);
    end

    ptw_addr_calc #(.PA_W(PA_W)) u_addr (
        .va_i    (va_q),
        .base_i  (base_q),
        .pos_i   (cur_pos),
        .width_i (cur_wid),
        .addr_o  (mem_addr_o)
    );

    ptw_result_fmt #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_fmt (
        .entry_i   (entry_q),
        .huge_i    (huge_q),
        .pos_i     (last_pos_q),
        .va_i      (va_q),
        .phys_o    (phys_o),
        .write_o   (write_o),
        .nomatch_o (nomatch_o)
    );

    p_req_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |=> !mem_req_o);

    p_req_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> !outstanding_q);

    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

    p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o);

    p_level_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (lvl_q <= TOP_LVL));

    p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mem_req_o);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam int PA_W = 48;
    localparam logic [63:0] PAM = (64'd1 << PA_W) - 64'd1;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              start_i = 1'b0;
    logic [63:0]       va_i = '0;
    logic [63:0]       root_lo_i = 64'h0000_0000_0010_0000;
    logic [63:0]       root_hi_i = 64'hF000_0000_0020_0000;
    logic [29:0]       cfg_pos_i;
    logic [29:0]       cfg_width_i;
    logic              busy_o, done_o, write_o, nomatch_o, mem_req_o;
    logic [63:0]       phys_o;
    logic [PA_W-1:0]   mem_addr_o;
    logic              mem_rvalid_i = 1'b0;
    logic [63:0]       mem_rdata_i = '0;

    always #2 clk_i = ~clk_i;

    ptw_walker #(.PA_W(PA_W), .PAGE_SHIFT(12)) dut (
        .clk_i, .rst_ni, .start_i, .va_i, .root_lo_i, .root_hi_i,
        .cfg_pos_i, .cfg_width_i, .busy_o, .done_o, .phys_o, .write_o,
        .nomatch_o, .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] mem [logic [47:0]];
    logic [47:0] exp_q [$];
    logic [63:0] exp_phys;
    logic        exp_wr, exp_nm;
    logic [47:0] next_tab = 48'h30_0000;
    int          lat_cur = 1;
    int          cnt = 0;
    logic        outstanding = 1'b0;
    logic [47:0] pend_addr;

    function automatic logic [63:0] rd(input logic [47:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic int pos_of(input int s);
        return int'(cfg_pos_i[s*6 +: 6]);
    endfunction

    function automatic int wid_of(input int s);
        return int'(cfg_width_i[s*6 +: 6]);
    endfunction

    function automatic logic [47:0] ent_addr(input logic [63:0] base, input logic [63:0] va, input int s);
        logic [63:0] idx;
        logic [63:0] a;
        idx = (va >> pos_of(s)) & ((64'd1 << wid_of(s)) - 64'd1);
        a = (base | (idx << 3)) & PAM;
        return a[47:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Plant a chain for va: directory pointers, then final entry at leaf or at huge_lvl.
    task automatic plant(input logic [63:0] va, input int huge_lvl, input logic [63:0] fin);
        logic [63:0] base;
        logic [47:0] a;
        base = (va[63] ? root_hi_i : root_lo_i) & PAM;
        for (int l = 4; l >= 1; l--) begin
            if (wid_of(l) == 0) continue;
            a = ent_addr(base, va, l);
            if (l == huge_lvl) begin
                mem[a] = fin;
                return;
            end
            mem[a] = {16'd0, next_tab};
            base = {16'd0, next_tab};
            next_tab = next_tab + 48'h1000;
        end
        a = ent_addr(base, va, 0);
        mem[a] = fin;
    endtask

    // Behavioural reference: expected read sequence and results.
    task automatic model(input logic [63:0] va);
        logic [63:0] base, e, offs;
        logic [47:0] a;
        bit huge;
        int lastpos;
        exp_q.delete();
        huge = 0;
        lastpos = 0;
        base = (va[63] ? root_hi_i : root_lo_i) & PAM;
        for (int l = 4; l >= 1; l--) begin
            if (wid_of(l) == 0) continue;
            a = ent_addr(base, va, l);
            exp_q.push_back(a);
            base = rd(a) & PAM;
            if (base[6]) begin
                huge = 1;
                lastpos = pos_of(l);
                break;
            end
        end
        if (huge) begin
            e = base;
            e[14:13] = 2'b00;
            e[6] = 1'b0;
            if (e[12]) begin
                e[12] = 1'b0;
                e[7] = 1'b1;
            end
        end else begin
            a = ent_addr(base, va, 0);
            exp_q.push_back(a);
            e = rd(a);
            lastpos = pos_of(0);
        end
        exp_nm = ~e[0];
        exp_wr = e[1];
        offs = va & PAM & ((64'd1 << lastpos) - 64'd1);
        exp_phys = e + offs;
        exp_phys[63:61] = 3'b000;
        exp_phys[11:0] = 12'd0;
    endtask

    // Memory responder and per-clock request checks (R3, R9).
    always @(negedge clk_i) begin
        if (mem_rvalid_i) mem_rvalid_i = 1'b0;
        if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i = rd(pend_addr);
                outstanding = 1'b0;
            end
        end
        if (mem_req_o && rst_ni) begin
            check(!outstanding, "R9 request while read pending", 64'(outstanding), 64'd0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected extra read", 64'(mem_addr_o), 64'd0);
            end else begin
                logic [47:0] ea;
                ea = exp_q.pop_front();
                check(mem_addr_o == ea, "R3 read address", 64'(mem_addr_o), 64'(ea));
            end
            outstanding = 1'b1;
            pend_addr = mem_addr_o;
            cnt = lat_cur;
        end
    end

    task automatic run_walk(input logic [63:0] va, input int lat, input string tag, input bit change_cfg);
        bit seen;
        logic [29:0] save_w;
        model(va);
        save_w = cfg_width_i;
        @(negedge clk_i);
        lat_cur = lat;
        va_i = va;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        check(busy_o == 1'b1, {"R10 busy after start ", tag}, 64'(busy_o), 64'd1);
        if (change_cfg) begin
            cfg_width_i = '0;
            root_lo_i = 64'h0000_0000_0ABC_0000;
            va_i = ~va;
        end
        seen = 0;
        for (int i = 0; i < 2000; i++) begin
            if (done_o) begin
                seen = 1;
                break;
            end
            @(negedge clk_i);
        end
        check(seen, {"R10 done reached ", tag}, 64'(seen), 64'd1);
        if (seen) begin
            check(phys_o == exp_phys, {"R8 phys ", tag}, phys_o, exp_phys);
            check(write_o == exp_wr, {"R7 write ", tag}, 64'(write_o), 64'(exp_wr));
            check(nomatch_o == exp_nm, {"R7 nomatch ", tag}, 64'(nomatch_o), 64'(exp_nm));
            check(exp_q.size() == 0, {"R2 read count ", tag}, 64'(exp_q.size()), 64'd0);
            check(busy_o == 1'b1, {"R10 busy at done ", tag}, 64'(busy_o), 64'd1);
            @(negedge clk_i);
            check(!done_o && !busy_o, {"R10 idle after done ", tag}, {62'd0, done_o, busy_o}, 64'd0);
        end
        if (change_cfg) begin
            cfg_width_i = save_w;
            root_lo_i = 64'h0000_0000_0010_0000;
        end
    endtask

    initial begin
        cfg_pos_i   = {6'd48, 6'd39, 6'd30, 6'd21, 6'd12};
        cfg_width_i = {6'd9, 6'd9, 6'd9, 6'd9, 6'd9};
        repeat (3) @(negedge clk_i);
        check(!busy_o && !done_o && !mem_req_o, "R10 reset state",
              {61'd0, busy_o, done_o, mem_req_o}, 64'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R2 R3 R6 R7: full four-level walk, writable page
        plant(64'h0000_1234_5678_9ABC, 0, 64'h0000_0000_0ABC_D003);
        run_walk(64'h0000_1234_5678_9ABC, 1, "four-level", 0);

        // R1: high-half root
        plant(64'h8000_0F0F_1234_5ABC, 0, 64'h0000_0001_2345_6003);
        run_walk(64'h8000_0F0F_1234_5ABC, 2, "high root", 0);

        // R7: dirty clear -> read only
        plant(64'h0000_0022_0000_1FFF, 0, 64'h0000_0000_0777_7001);
        run_walk(64'h0000_0022_0000_1FFF, 3, "read-only", 0);

        // R7: valid clear -> no-match
        plant(64'h0000_0033_4444_5000, 0, 64'h0000_0000_0555_5002);
        run_walk(64'h0000_0033_4444_5000, 1, "invalid leaf", 0);

        // R8: top attribute bits cleared in result
        plant(64'h0000_0044_1111_2345, 0, 64'hE000_0000_0123_4003);
        run_walk(64'h0000_0044_1111_2345, 2, "top bits", 0);

        // R4 R5: huge at level 2, huge-global set, level bits set
        plant(64'h0000_0055_2ABC_DEF0, 2, 64'h0000_0000_C000_7043);
        run_walk(64'h0000_0055_2ABC_DEF0, 1, "huge L2 global", 0);

        // R5: huge at level 1 without huge-global
        plant(64'h0000_0066_0013_5790, 1, 64'h0000_0001_0020_2041);
        run_walk(64'h0000_0066_0013_5790, 2, "huge L1", 0);

        // R4: fetched directory entry masked to PA_W (high bits set in pointer entry)
        cfg_width_i = {6'd0, 6'd0, 6'd0, 6'd9, 6'd9};
        mem[ent_addr(root_lo_i & PAM, 64'h0000_0000_0020_3000, 1)] = 64'hFFFF_0000_0040_0000;
        mem[ent_addr(64'h0000_0000_0040_0000, 64'h0000_0000_0020_3000, 0)] = 64'h0000_0000_0999_9003;
        run_walk(64'h0000_0000_0020_3000, 1, "masked dir", 0);

        // R2: levels 4 and 3 skipped
        cfg_width_i = {6'd0, 6'd0, 6'd9, 6'd9, 6'd9};
        plant(64'h0000_0000_4321_8765, 0, 64'h0000_0000_0246_8003);
        run_walk(64'h0000_0000_4321_8765, 1, "skip L4 L3", 0);

        // R2 R6: all directory levels skipped, only leaf read from root
        cfg_width_i = {6'd0, 6'd0, 6'd0, 6'd0, 6'd9};
        plant(64'h0000_0000_0012_3456, 0, 64'h0000_0000_0135_7003);
        run_walk(64'h0000_0000_0012_3456, 2, "leaf only", 0);

        // R11: configuration and root changed mid-walk are ignored
        cfg_width_i = {6'd9, 6'd9, 6'd9, 6'd9, 6'd9};
        plant(64'h0000_0077_89AB_CDEF, 0, 64'h0000_0000_0FED_C003);
        run_walk(64'h0000_0077_89AB_CDEF, 3, "cfg change R11", 1);

        // R10: walk after the changed one starts cleanly
        plant(64'h0000_0011_0000_0000, 0, 64'h0000_0000_0000_1003);
        run_walk(64'h0000_0011_0000_0000, 1, "back-to-back", 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule